// File: doc/BRIEF.md
# Direct-Mapped Data Cache Write Controller

This block controls the write path of a direct-mapped data cache with 512 lines of 32 bytes. The CPU presents one access at a time: an address, a read or write flag, an access size, lane-positioned write data, and a per-access mode flag that chooses copy-back or write-through. The block holds the tag, valid and dirty arrays and the line data. It decides whether the access can complete at once or must stall.

Toward external memory it has two ports. A longword read port refills lines. A write port carries write-through stores and the write-back of evicted lines. A copy-back write miss is accepted at once. The store goes into the line first. The remaining longwords are then fetched in wraparound order, starting at the stored longword, and store bytes are never overwritten. If the victim line is dirty, it is first copied whole into a one-entry buffer. That buffer drains to memory only after the fill has finished. Read hits return one doubleword; a read miss refills the line and then completes.

Top module: `dcache_write_ctrl`

## Requirements
- R1: Address bits [13:5] pick the line, bits [4:0] the byte within it, and bits [31:14] form the tag; every external address is built from these fields (longword addresses have bits [1:0] zero).
- R2: size_i encodes 0 byte, 1 word, 2 longword, 3 quadword; wdata_i carries each byte on the lane of its address bits [2:0]; only the addressed bytes of a line change.
- R3: A copy-back write hit updates the cached bytes, marks the line dirty and issues no external write.
- R4: A write-through hit updates the cached bytes and issues exactly one external write with the same address, size and data; the write request holds its address until acknowledged.
- R5: A write-through miss issues only the external write; the line stays absent, so a later read of it still misses and refills.
- R6: A copy-back write miss is accepted without stall; its bytes enter the line before the fill and survive it.
- R7: A fill requests longwords in ascending wraparound order from the longword holding the access address; longwords fully covered by the store are not requested.
- R8: During a fill, accesses to other lines proceed; the tag is written only after the last fill longword, with the valid bit set and the dirty bit set for a write miss.
- R9: On a miss whose victim is valid and dirty, the victim line is written out after the last fill request as eight longwords in ascending order at the address rebuilt from its tag and index.
- R10: An access to the line under fill stalls until the fill ends; a miss stalls until the fill, any write-back and any pending write-through are done.
- R11: A read hit is accepted without stall and rvalid_o pulses one cycle later with the doubleword at address bits [4:3] on rdata_o.
- R12: After reset all lines are invalid and clean, and no fill or external write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU access request |
| we_i | input | 1 | 1 write, 0 read |
| cb_i | input | 1 | 1 copy-back, 0 write-through |
| addr_i | input | 32 | Byte address |
| size_i | input | 2 | Access size code |
| wdata_i | input | 64 | Lane-positioned write data |
| stall_o | output | 1 | Access not taken this cycle |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 64 | Read doubleword |
| fill_req_o | output | 1 | Fill longword request |
| fill_addr_o | output | 32 | Fill longword address |
| fill_ack_i | input | 1 | Fill data returned |
| fill_data_i | input | 32 | Fill longword |
| mem_we_o | output | 1 | External write request |
| mem_addr_o | output | 32 | External write address |
| mem_size_o | output | 2 | External write size code |
| mem_wdata_o | output | 64 | Lane-positioned external write data |
| mem_ack_i | input | 1 | External write taken |

## Verification
An accepted access changes the arrays at its clock edge: a read of the same line one cycle later sees the store, and read data shows up on the edge after acceptance. Fill and external write requests appear the cycle after the accepting edge, and each is consumed by the edge on which it is acknowledged. The write-back starts the cycle after the final fill acknowledge. The bench drives and samples on the falling edge, acknowledges requests there, and logs each request with its cycle number. Order and timing checks therefore compare logged cycle stamps and list positions, not fixed delays.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_QUAD = 2'd3} size_e;

  function automatic logic [7:0] lane_mask(input logic [1:0] sz, input logic [2:0] ofs);
    unique case (sz)
      2'd0:    return 8'h01 << ofs;
      2'd1:    return 8'h03 << {ofs[2:1], 1'b0};
      2'd2:    return 8'h0F << {ofs[2], 2'b00};
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cwc_tag_store.sv
module cwc_tag_store #(
  parameter int LINES = 512,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic             rd_dirty_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             dirty_set_i,
  input  logic [IDX_W-1:0] dirty_idx_i,
  input  logic             inval_i,
  input  logic [IDX_W-1:0] inval_idx_i,
  input  logic             inst_i,
  input  logic [IDX_W-1:0] inst_idx_i,
  input  logic [TAG_W-1:0] inst_tag_i,
  input  logic             inst_dirty_i
);
  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (dirty_set_i) dirty_q[dirty_idx_i] <= 1'b1;
      if (inval_i) begin
        valid_q[inval_idx_i] <= 1'b0;
        dirty_q[inval_idx_i] <= 1'b0;
      end
      if (inst_i) begin
        valid_q[inst_idx_i] <= 1'b1;
        dirty_q[inst_idx_i] <= inst_dirty_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (inst_i) tag_q[inst_idx_i] <= inst_tag_i;
  end

  // line under fill was invalidated at fill start
  a_r8_install_on_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_i |-> !valid_q[inst_idx_i]);
endmodule

// File: rtl/cwc_data_store.sv
module cwc_data_store #(
  parameter int LINES      = 512,
  parameter int LINE_BYTES = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int LW_W   = $clog2(LINE_BYTES / 4)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [LINE_W-1:0]     rd_line_o,
  input  logic                  a_en_i,
  input  logic [IDX_W-1:0]      a_idx_i,
  input  logic [LINE_BYTES-1:0] a_mask_i,
  input  logic [LINE_W-1:0]     a_data_i,
  input  logic                  b_en_i,
  input  logic [IDX_W-1:0]      b_idx_i,
  input  logic [LW_W-1:0]       b_lw_i,
  input  logic [3:0]            b_be_i,
  input  logic [31:0]           b_data_i
);
  logic [LINE_W-1:0] mem_q [LINES];

  assign rd_line_o = mem_q[rd_idx_i];

  always_ff @(posedge clk_i) begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (a_en_i && a_mask_i[b]) mem_q[a_idx_i][b*8 +: 8] <= a_data_i[b*8 +: 8];
    end
    for (int k = 0; k < 4; k++) begin
      if (b_en_i && b_be_i[k]) mem_q[b_idx_i][int'(b_lw_i)*32 + k*8 +: 8] <= b_data_i[k*8 +: 8];
    end
  end

  // CPU stores never touch the line being filled
  a_r10_no_store_into_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && b_en_i) |-> (a_idx_i != b_idx_i));
endmodule

// File: rtl/cwc_fill.sv
module cwc_fill #(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 512,
  parameter int LINE_BYTES = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFS_W = $clog2(LINE_BYTES),
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W,
  localparam int LWS   = LINE_BYTES / 4,
  localparam int LW_W  = $clog2(LWS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [IDX_W-1:0]      start_idx_i,
  input  logic [TAG_W-1:0]      start_tag_i,
  input  logic [LW_W-1:0]       start_lw_i,
  input  logic [LINE_BYTES-1:0] keep_i,
  input  logic                  dirty_i,
  output logic                  busy_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic                  fill_req_o,
  output logic [ADDR_W-1:0]     fill_addr_o,
  input  logic                  fill_ack_i,
  input  logic [31:0]           fill_data_i,
  output logic                  wr_en_o,
  output logic [LW_W-1:0]       wr_lw_o,
  output logic [3:0]            wr_be_o,
  output logic [31:0]           wr_data_o,
  output logic                  inst_o,
  output logic [TAG_W-1:0]      inst_tag_o,
  output logic                  inst_dirty_o
);
  logic                  busy_q, dirty_q;
  logic [IDX_W-1:0]      idx_q;
  logic [TAG_W-1:0]      tag_q;
  logic [LW_W-1:0]       ptr_q, cnt_q;
  logic [LINE_BYTES-1:0] keep_q;
  logic [3:0]            cur_keep;
  logic                  skip, step, last;

  assign cur_keep = keep_q[int'(ptr_q)*4 +: 4];
  assign skip     = &cur_keep;
  assign step     = busy_q && (skip || fill_ack_i);
  assign last     = step && (cnt_q == LW_W'(LWS - 1));

  assign busy_o       = busy_q;
  assign idx_o        = idx_q;
  assign fill_req_o   = busy_q && !skip;
  assign fill_addr_o  = {tag_q, idx_q, ptr_q, 2'b00};
  assign wr_en_o      = busy_q && !skip && fill_ack_i;
  assign wr_lw_o      = ptr_q;
  assign wr_be_o      = ~cur_keep;
  assign wr_data_o    = fill_data_i;
  assign inst_o       = last;
  assign inst_tag_o   = tag_q;
  assign inst_dirty_o = dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      dirty_q <= 1'b0;
      idx_q   <= '0;
      tag_q   <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      keep_q  <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      dirty_q <= dirty_i;
      idx_q   <= start_idx_i;
      tag_q   <= start_tag_i;
      ptr_q   <= start_lw_i;
      cnt_q   <= '0;
      keep_q  <= keep_i;
    end else if (step) begin
      ptr_q <= ptr_q + 1'b1;
      cnt_q <= cnt_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/cwc_wb_buf.sv
module cwc_wb_buf #(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 512,
  parameter int LINE_BYTES = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int LWS    = LINE_BYTES / 4,
  localparam int LW_W   = $clog2(LWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  load_idx_i,
  input  logic [TAG_W-1:0]  load_tag_i,
  input  logic [LINE_W-1:0] load_line_i,
  input  logic              fill_busy_i,
  input  logic              ack_i,
  output logic              pend_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [31:0]       lw_o
);
  logic              pend_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] line_q;
  logic [LW_W-1:0]   ptr_q;

  assign pend_o = pend_q;
  assign req_o  = pend_q && !fill_busy_i;
  assign addr_o = {tag_q, idx_q, ptr_q, 2'b00};
  assign lw_o   = line_q[int'(ptr_q)*32 +: 32];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      idx_q  <= '0;
      tag_q  <= '0;
      line_q <= '0;
      ptr_q  <= '0;
    end else if (load_i) begin
      pend_q <= 1'b1;
      idx_q  <= load_idx_i;
      tag_q  <= load_tag_i;
      line_q <= load_line_i;
      ptr_q  <= '0;
    end else if (req_o && ack_i) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == LW_W'(LWS - 1)) pend_q <= 1'b0;
    end
  end

  a_r9_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !pend_q);
endmodule

// File: rtl/dcache_write_ctrl.sv
module dcache_write_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 512,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              cb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [63:0]       wdata_i,
  output logic              stall_o,
  output logic              rvalid_o,
  output logic [63:0]       rdata_o,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_ack_i,
  input  logic [31:0]       fill_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [63:0]       mem_wdata_o,
  input  logic              mem_ack_i
);
  import cwc_pkg::*;

  localparam int IDX_W  = $clog2(LINES);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int DWS    = LINE_BYTES / 8;
  localparam int DW_W   = $clog2(DWS);
  localparam int LW_W   = $clog2(LINE_BYTES / 4);

  logic [IDX_W-1:0]      idx;
  logic [TAG_W-1:0]      tag;
  logic [DW_W-1:0]       dw;
  logic [LINE_BYTES-1:0] line_mask;
  logic [LINE_W-1:0]     line_wdata, rd_line;
  logic                  v_rd, d_rd, hit;
  logic [TAG_W-1:0]      t_rd;

  logic                  fill_busy, start_fill, on_fill_line, engines_idle;
  logic [IDX_W-1:0]      fill_idx;
  logic                  f_wr_en, f_inst, f_inst_dirty;
  logic [LW_W-1:0]       f_wr_lw;
  logic [3:0]            f_wr_be;
  logic [31:0]           f_wr_data;
  logic [TAG_W-1:0]      f_inst_tag;

  logic                  wb_pend, wb_req;
  logic [ADDR_W-1:0]     wb_addr;
  logic [31:0]           wb_lw;

  logic                  wt_pend_q;
  logic [ADDR_W-1:0]     wt_addr_q;
  logic [1:0]            wt_size_q;
  logic [63:0]           wt_data_q;

  logic                  stall, accept, cpu_store;

  assign idx        = addr_i[OFS_W +: IDX_W];
  assign tag        = addr_i[ADDR_W-1 -: TAG_W];
  assign dw         = addr_i[OFS_W-1:3];
  assign line_mask  = LINE_BYTES'(lane_mask(size_i, addr_i[2:0])) << {dw, 3'b000};
  assign line_wdata = {DWS{wdata_i}};
  assign hit        = v_rd && (t_rd == tag);

  assign on_fill_line = fill_busy && (idx == fill_idx);
  assign engines_idle = !fill_busy && !wb_pend && !wt_pend_q;

  always_comb begin
    stall      = 1'b0;
    start_fill = 1'b0;
    if (req_i) begin
      if (on_fill_line) begin
        stall = 1'b1;
      end else if (!we_i) begin
        if (!hit) begin
          stall      = 1'b1;
          start_fill = engines_idle;
        end
      end else if (cb_i) begin
        if (!hit) begin
          if (engines_idle) start_fill = 1'b1;
          else              stall      = 1'b1;
        end
      end else if (wt_pend_q || wb_pend) begin
        stall = 1'b1;
      end
    end
  end

  assign stall_o   = stall;
  assign accept    = req_i && !stall;
  assign cpu_store = accept && we_i && (cb_i || hit);

  cwc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
    .clk_i, .rst_ni,
    .rd_idx_i     (idx),
    .rd_valid_o   (v_rd),
    .rd_dirty_o   (d_rd),
    .rd_tag_o     (t_rd),
    .dirty_set_i  (accept && we_i && cb_i && hit),
    .dirty_idx_i  (idx),
    .inval_i      (start_fill),
    .inval_idx_i  (idx),
    .inst_i       (f_inst),
    .inst_idx_i   (fill_idx),
    .inst_tag_i   (f_inst_tag),
    .inst_dirty_i (f_inst_dirty)
  );

  cwc_data_store #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) i_data (
    .clk_i, .rst_ni,
    .rd_idx_i  (idx),
    .rd_line_o (rd_line),
    .a_en_i    (cpu_store),
    .a_idx_i   (idx),
    .a_mask_i  (line_mask),
    .a_data_i  (line_wdata),
    .b_en_i    (f_wr_en),
    .b_idx_i   (fill_idx),
    .b_lw_i    (f_wr_lw),
    .b_be_i    (f_wr_be),
    .b_data_i  (f_wr_data)
  );

  cwc_fill #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES)) i_fill (
    .clk_i, .rst_ni,
    .start_i      (start_fill),
    .start_idx_i  (idx),
    .start_tag_i  (tag),
    .start_lw_i   (addr_i[OFS_W-1:2]),
    .keep_i       (we_i ? line_mask : '0),
    .dirty_i      (we_i),
    .busy_o       (fill_busy),
    .idx_o        (fill_idx),
    .fill_req_o,
    .fill_addr_o,
    .fill_ack_i,
    .fill_data_i,
    .wr_en_o      (f_wr_en),
    .wr_lw_o      (f_wr_lw),
    .wr_be_o      (f_wr_be),
    .wr_data_o    (f_wr_data),
    .inst_o       (f_inst),
    .inst_tag_o   (f_inst_tag),
    .inst_dirty_o (f_inst_dirty)
  );

  // victim is read before the store merge lands at the same edge
  cwc_wb_buf #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES)) i_wb (
    .clk_i, .rst_ni,
    .load_i      (start_fill && v_rd && d_rd),
    .load_idx_i  (idx),
    .load_tag_i  (t_rd),
    .load_line_i (rd_line),
    .fill_busy_i (fill_busy),
    .ack_i       (mem_ack_i && !wt_pend_q),
    .pend_o      (wb_pend),
    .req_o       (wb_req),
    .addr_o      (wb_addr),
    .lw_o        (wb_lw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wt_pend_q <= 1'b0;
      wt_addr_q <= '0;
      wt_size_q <= '0;
      wt_data_q <= '0;
    end else if (accept && we_i && !cb_i) begin
      wt_pend_q <= 1'b1;
      wt_addr_q <= addr_i;
      wt_size_q <= size_i;
      wt_data_q <= wdata_i;
    end else if (wt_pend_q && mem_ack_i) begin
      wt_pend_q <= 1'b0;
    end
  end

  assign mem_we_o    = wt_pend_q || wb_req;
  assign mem_addr_o  = wt_pend_q ? wt_addr_q : wb_addr;
  assign mem_size_o  = wt_pend_q ? wt_size_q : SZ_LONG;
  assign mem_wdata_o = wt_pend_q ? wt_data_q : {2{wb_lw}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= accept && !we_i;
      if (accept && !we_i) rdata_o <= rd_line[int'(dw)*64 +: 64];
    end
  end

  a_r4_port_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_ack_i) |=> (mem_we_o && $stable(mem_addr_o)));

  a_r11_read_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !stall_o) |-> (v_rd && !on_fill_line));
endmodule

// File: tb/test_dcache_write_ctrl.sv
`timescale 1ns/100ps
module test_dcache_write_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, cb_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [63:0] wdata_i = '0;
  logic        stall_o, rvalid_o;
  logic [63:0] rdata_o;
  logic        fill_req_o, fill_ack_i = 1'b0;
  logic [31:0] fill_addr_o, fill_data_i = '0;
  logic        mem_we_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic [1:0]  mem_size_o;
  logic [63:0] mem_wdata_o;

  dcache_write_ctrl i_dcache_write_ctrl (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  logic [31:0] f_addr [64];
  int          f_cyc  [64];
  int          f_n = 0;
  logic [31:0] w_addr [64];
  logic [63:0] w_data [64];
  logic [1:0]  w_size [64];
  int          w_cyc  [64];
  int          w_n = 0;

  function automatic logic [31:0] fdat(input logic [31:0] a);
    return {16'hC0DE, a[15:0]};
  endfunction

  always @(posedge clk_i) cyc <= cyc + 1;

  // memory model: acknowledge every request seen at the falling edge
  always @(negedge clk_i) begin
    fill_ack_i  = fill_req_o;
    fill_data_i = fdat(fill_addr_o);
    if (fill_req_o && f_n < 64) begin
      f_addr[f_n] = fill_addr_o; f_cyc[f_n] = cyc; f_n++;
    end
    mem_ack_i = mem_we_o;
    if (mem_we_o && w_n < 64) begin
      w_addr[w_n] = mem_addr_o; w_data[w_n] = mem_wdata_o;
      w_size[w_n] = mem_size_o; w_cyc[w_n] = cyc; w_n++;
    end
  end

  always @(posedge clk_i) begin
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input bit cb, input logic [31:0] a, input logic [1:0] sz,
                        input logic [63:0] d, output int stalls, output logic [63:0] rd);
    stalls = 0;
    rd = '0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; cb_i = cb; addr_i = a; size_i = sz; wdata_i = d;
    #1;
    while (stall_o && stalls < 500) begin
      @(negedge clk_i); #1; stalls++;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    #1;
    if (!we) rd = rdata_o;
  endtask

  task automatic wait_wr(input int target);
    for (int g = 0; g < 200 && w_n < target; g++) @(negedge clk_i);
  endtask

  task automatic t_reset;
    @(negedge clk_i); #1;
    chk(!stall_o, "R12 stall", 64'(stall_o), 0);
    chk(!fill_req_o, "R12 fill_req", 64'(fill_req_o), 0);
    chk(!mem_we_o, "R12 mem_we", 64'(mem_we_o), 0);
    chk(!rvalid_o, "R12 rvalid", 64'(rvalid_o), 0);
  endtask

  task automatic t_cb_miss_clean;
    int s; logic [63:0] rd; int fs, ws;
    fs = f_n; ws = w_n;
    cpu_op(1, 1, 32'h1024, 2'd0, 64'h0000_005A_0000_0000, s, rd);
    chk(s == 0, "R6 cb miss no stall", 64'(s), 0);
    cpu_op(1, 0, 32'h7000, 2'd2, 64'h0000_0000_AAAA_5555, s, rd);
    chk(s == 0, "R8 other line during fill", 64'(s), 0);
    cpu_op(0, 0, 32'h1020, 2'd3, 64'h0, s, rd);
    chk(s > 0, "R10 stall on fill line", 64'(s), 1);
    chk(rd == {32'hC0DE105A, 32'hC0DE1020}, "R6 store kept after fill", rd, {32'hC0DE105A, 32'hC0DE1020});
    for (int i = 0; i < 8; i++) begin
      logic [31:0] e;
      e = 32'h1020 + 32'(((1 + i) % 8) * 4);
      chk(f_addr[fs+i] == e, "R7 wraparound order", 64'(f_addr[fs+i]), 64'(e));
    end
    chk(w_n > ws && w_addr[ws] == 32'h7000, "R5 wt miss write", 64'(w_addr[ws]), 64'h7000);
  endtask

  task automatic t_cb_hit;
    int s, ws; logic [63:0] rd;
    ws = w_n;
    cpu_op(1, 1, 32'h1026, 2'd1, 64'hBEEF_0000_0000_0000, s, rd);
    chk(s == 0, "R3 hit no stall", 64'(s), 0);
    repeat (4) @(negedge clk_i);
    chk(w_n == ws, "R3 no external write", 64'(w_n), 64'(ws));
    cpu_op(0, 0, 32'h1020, 2'd3, 64'h0, s, rd);
    chk(s == 0, "R11 read hit no stall", 64'(s), 0);
    chk(rd == {32'hBEEF105A, 32'hC0DE1020}, "R2 word bytes only", rd, {32'hBEEF105A, 32'hC0DE1020});
    @(negedge clk_i); #1;
    chk(!rvalid_o, "R11 rvalid single pulse", 64'(rvalid_o), 0);
  endtask

  task automatic t_fill_quad;
    int s, fs; logic [63:0] rd;
    fs = f_n;
    cpu_op(1, 1, 32'h2018, 2'd3, 64'h1111_2222_3333_4444, s, rd);
    cpu_op(0, 0, 32'h2018, 2'd3, 64'h0, s, rd);
    chk(rd == 64'h1111_2222_3333_4444, "R2 quad store", rd, 64'h1111_2222_3333_4444);
    chk(f_n - fs == 6, "R7 covered longwords skipped", 64'(f_n - fs), 6);
    for (int i = 0; i < 6; i++)
      chk(f_addr[fs+i] == 32'h2000 + 32'(i*4), "R7 quad fill order", 64'(f_addr[fs+i]), 64'(32'h2000 + i*4));
  endtask

  task automatic t_wt_hit;
    int s, ws; logic [63:0] rd;
    ws = w_n;
    cpu_op(1, 0, 32'h2008, 2'd2, 64'h0000_0000_1234_5678, s, rd);
    wait_wr(ws + 1);
    chk(w_n == ws + 1 && w_addr[ws] == 32'h2008, "R4 wt addr", 64'(w_addr[ws]), 64'h2008);
    chk(w_size[ws] == 2'd2, "R4 wt size", 64'(w_size[ws]), 2);
    chk(w_data[ws][31:0] == 32'h1234_5678, "R4 wt data", w_data[ws], 64'h1234_5678);
    cpu_op(0, 0, 32'h2008, 2'd3, 64'h0, s, rd);
    chk(rd == {32'hC0DE200C, 32'h1234_5678}, "R4 cache updated", rd, {32'hC0DE200C, 32'h1234_5678});
  endtask

  task automatic t_wt_miss;
    int s, ws, fs; logic [63:0] rd;
    ws = w_n; fs = f_n;
    cpu_op(1, 0, 32'h3001, 2'd0, 64'h0000_0000_0000_BB00, s, rd);
    cpu_op(0, 0, 32'h3000, 2'd3, 64'h0, s, rd);
    chk(w_addr[ws] == 32'h3001 && w_size[ws] == 2'd0, "R5 wt miss external", 64'(w_addr[ws]), 64'h3001);
    chk(f_n - fs == 8 && f_addr[fs] == 32'h3000, "R5 line stayed absent", 64'(f_n - fs), 8);
    chk(rd == {32'hC0DE3004, 32'hC0DE3000}, "R5 cache not written", rd, {32'hC0DE3004, 32'hC0DE3000});
  endtask

  task automatic t_evict;
    int s, fs, ws; logic [63:0] rd;
    fs = f_n; ws = w_n;
    cpu_op(1, 1, 32'h5024, 2'd2, 64'h7777_8888_0000_0000, s, rd);
    chk(s == 0, "R6 dirty victim no stall", 64'(s), 0);
    cpu_op(0, 0, 32'h9000, 2'd3, 64'h0, s, rd);
    chk(w_n - ws == 8, "R9 eight write-backs", 64'(w_n - ws), 8);
    for (int i = 0; i < 7; i++) begin
      logic [31:0] e;
      e = 32'h5020 + 32'(((2 + i) % 8) * 4);
      chk(f_addr[fs+i] == e, "R1 R7 miss fill address", 64'(f_addr[fs+i]), 64'(e));
    end
    for (int k = 0; k < 8; k++) begin
      logic [31:0] ea, ed;
      ea = 32'h1020 + 32'(k*4);
      ed = (k == 0) ? 32'hC0DE1020 : (k == 1) ? 32'hBEEF105A : fdat(ea);
      chk(w_addr[ws+k] == ea, "R9 write-back address", 64'(w_addr[ws+k]), 64'(ea));
      chk(w_data[ws+k][31:0] == ed, "R9 write-back data", w_data[ws+k], 64'(ed));
    end
    chk(w_cyc[ws] > f_cyc[fs+6], "R9 write-back after fill", 64'(w_cyc[ws]), 64'(f_cyc[fs+6] + 1));
    chk(f_addr[fs+7] == 32'h9000 && f_cyc[fs+7] > w_cyc[ws+7], "R10 miss waits for write-back",
        64'(f_cyc[fs+7]), 64'(w_cyc[ws+7] + 1));
    cpu_op(0, 0, 32'h5020, 2'd3, 64'h0, s, rd);
    chk(s == 0, "R8 installed valid", 64'(s), 0);
    chk(rd == {32'h7777_8888, 32'hC0DE5020}, "R6 evict store kept", rd, {32'h7777_8888, 32'hC0DE5020});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_cb_miss_clean();
    t_cb_hit();
    t_fill_quad();
    t_wt_hit();
    t_wt_miss();
    t_evict();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule